// File: doc/BRIEF.md
# RGB LED Matrix Scan Driver

This block refreshes a 64-column by 32-row on/off RGB LED panel wired as two halves, upper and lower, each of 16 line pairs. The halves are driven together. On every shift-clock period the block presents six colour bits, red, green and blue for the upper half and the same three for the lower half, all taken from the same column. After a full line has been clocked in, the block latches it into the panel drivers, moves the line address to that line, and lights it for a programmable on-time. It then starts on the next line.

Pixel storage is a frame buffer inside the block, one memory per half. The scan side reads it over its own port. A host write stream fills it. The stream has a valid/ready pair, but ready is held high at all times: writes never exert back-pressure and never stall the scan. A beat is taken on any clock where valid is high. The shift clock is the system clock divided by a parameter, so the panel's 25 MHz limit holds whenever that parameter is at least 1 on a 50 MHz system clock.

Top module: `led_panel_scan`

## Requirements
- R1: While reset is held, and in the first cycle after it, `panel_oe_n` is 1, `panel_sclk` and `panel_latch` are 0, and `panel_addr` is 0. `wr_ready` is 1.
- R2: A write beat is taken on every clock with `wr_valid` = 1. `wr_addr` is {row[4:0], col[5:0]}. Rows 0–15 are upper-half lines 0–15 and rows 16–31 are lower-half lines 0–15. `wr_data` is {R,G,B} with R in bit 2, and 1 means lit. When `wr_valid` = 0 the buffer is left unchanged.
- R3: Between two latch pulses, `panel_sclk` has exactly COLS rising edges. Column 0 is shifted first, so after a line column c sits COLS-1-c stages from the input of a panel shift register.
- R4: `panel_rgb_top` and `panel_rgb_bot` ({R,G,B}, R in bit 2) do not change while `panel_sclk` is high. They change only together with its falling edge.
- R5: During a line, `panel_sclk` is high for exactly HALF_CYC system clocks and low for at least HALF_CYC system clocks.
- R6: `panel_latch` is high only while `panel_oe_n` is 1 and `panel_sclk` is 0.
- R7: `panel_addr` changes only between two clocks that both have `panel_oe_n` = 1.
- R8: After each latch, `panel_oe_n` goes low for exactly ON_CYC system clocks.
- R9: Line addresses step 0,1,…,15 and then wrap to 0. Each step is one per latched line.
- R10: The line latched while `panel_addr` = L holds, for every column, the buffer pixels of row L (upper) and row L+16 (lower).
- R11: Writes issued while scanning is under way are all accepted. Their values appear in the rows latched after they complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write beat present |
| wr_ready | output | 1 | Always 1; writes are never refused |
| wr_addr | input | 11 | {row, col} of the pixel written |
| wr_data | input | 3 | Pixel value {R,G,B} |
| panel_sclk | output | 1 | Panel shift clock; panel samples on rising edge |
| panel_latch | output | 1 | Panel latch strobe; rising edge moves the line to the drivers |
| panel_oe_n | output | 1 | Panel output enable, active low |
| panel_addr | output | 4 | Line pair being displayed |
| panel_rgb_top | output | 3 | Upper-half colour bits {R,G,B} |
| panel_rgb_bot | output | 3 | Lower-half colour bits {R,G,B} |

## Verification
The bench models the panel's six shift registers and their latches, fills every pixel with a computed pattern, and compares every latched line of both halves against that pattern. A column-order or off-by-one fetch bug shows up as rotated or shifted rows. A read-latency slip puts stale data on the first column.

A second pattern is written while the scan runs. A buffer that drops writes or stalls the scan leaves old pixels behind. A write attempted with valid low must not land. Address changes while lit, data moving during the high half of the shift clock, a wrong shift-clock width and a wrong on-time are all timed against the system clock, because a divider or sequencer off by one would otherwise still light the right pixels.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

  localparam int RGB_W = 3;

  typedef logic [RGB_W-1:0] rgb_t;

  typedef enum logic [2:0] {
    SEQ_PREP,
    SEQ_SHIFT,
    SEQ_LATCH,
    SEQ_ADDR,
    SEQ_ON
  } seq_state_t;

endpackage

// File: rtl/led_fb_half.sv
module led_fb_half
  import led_scan_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  rgb_t          wdata,
  input  logic [AW-1:0] raddr,
  output rgb_t          rdata
);

  rgb_t mem [DEPTH];

  // write port: one pixel per clock, no arbitration with the read side
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read port: registered, one clock of latency
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/led_scan_seq.sv
module led_scan_seq
  import led_scan_pkg::*;
#(
  parameter int COLS     = 64,
  parameter int LINES    = 16,
  parameter int HALF_CYC = 1,
  parameter int ON_CYC   = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic [$clog2(LINES)-1:0] rd_line,
  output logic [$clog2(COLS)-1:0]  rd_col,
  output logic                     ld_px,
  output logic                     sclk,
  output logic                     latch,
  output logic                     oe_n,
  output logic [$clog2(LINES)-1:0] addr
);

  localparam int CW    = $clog2(COLS);
  localparam int LW    = $clog2(LINES);
  localparam int MAXC  = (ON_CYC > HALF_CYC) ? ((ON_CYC > 2) ? ON_CYC : 2)
                                              : ((HALF_CYC > 2) ? HALF_CYC : 2);
  localparam int CNT_W = $clog2(MAXC + 1);

  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] ON_LAST   = CNT_W'(ON_CYC - 1);
  localparam logic [CNT_W-1:0] PREP_LAST = CNT_W'(1);
  localparam logic [CW-1:0]    COL_LAST  = CW'(COLS - 1);
  localparam logic [LW-1:0]    LINE_LAST = LW'(LINES - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] ph;
  logic             hi;
  logic [CW-1:0]    col;
  logic [LW-1:0]    line;
  logic [LW-1:0]    disp;
  logic [CW-1:0]    fetch;

  logic ph_end_half;
  assign ph_end_half = (ph == HALF_LAST);

  // load strobe: at the end of preparation, and at each falling shift edge
  // except after the last column
  always_comb begin
    ld_px = 1'b0;
    if (state == SEQ_PREP && ph == PREP_LAST) ld_px = 1'b1;
    if (state == SEQ_SHIFT && hi && ph_end_half && col != COL_LAST) ld_px = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_PREP;
      ph    <= '0;
      hi    <= 1'b0;
      col   <= '0;
      line  <= '0;
      disp  <= '0;
      fetch <= '0;
    end else begin
      if (ld_px) fetch <= fetch + 1'b1;
      unique case (state)
        SEQ_PREP: begin
          if (ph == PREP_LAST) begin
            ph    <= '0;
            hi    <= 1'b0;
            col   <= '0;
            state <= SEQ_SHIFT;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        SEQ_SHIFT: begin
          if (ph_end_half) begin
            ph <= '0;
            if (!hi) begin
              hi <= 1'b1;
            end else begin
              hi <= 1'b0;
              if (col == COL_LAST) state <= SEQ_LATCH;
              else                 col   <= col + 1'b1;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        SEQ_LATCH: begin
          if (ph_end_half) begin
            ph    <= '0;
            disp  <= line;
            state <= SEQ_ADDR;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        SEQ_ADDR: begin
          ph    <= '0;
          state <= SEQ_ON;
        end
        SEQ_ON: begin
          if (ph == ON_LAST) begin
            ph    <= '0;
            fetch <= '0;
            line  <= (line == LINE_LAST) ? '0 : line + 1'b1;
            state <= SEQ_PREP;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: state <= SEQ_PREP;
      endcase
    end
  end

  assign rd_line = line;
  assign rd_col  = fetch;
  assign sclk    = (state == SEQ_SHIFT) && hi;
  assign latch   = (state == SEQ_LATCH);
  assign oe_n    = (state != SEQ_ON);
  assign addr    = disp;

endmodule

// File: rtl/led_panel_scan.sv
module led_panel_scan
  import led_scan_pkg::*;
#(
  parameter int COLS     = 64,
  parameter int LINES    = 16,
  parameter int HALF_CYC = 1,
  parameter int ON_CYC   = 64
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    wr_valid,
  output logic                                    wr_ready,
  input  logic [$clog2(LINES)+$clog2(COLS):0]     wr_addr,
  input  logic [2:0]                              wr_data,
  output logic                                    panel_sclk,
  output logic                                    panel_latch,
  output logic                                    panel_oe_n,
  output logic [$clog2(LINES)-1:0]                panel_addr,
  output logic [2:0]                              panel_rgb_top,
  output logic [2:0]                              panel_rgb_bot
);

  localparam int CW    = $clog2(COLS);
  localparam int LW    = $clog2(LINES);
  localparam int AW    = LW + CW;
  localparam int DEPTH = LINES * COLS;
  localparam int HALVES = 2;

  logic [LW-1:0] rd_line;
  logic [CW-1:0] rd_col;
  logic          ld_px;
  logic [AW-1:0] fb_raddr;
  rgb_t          fb_q [HALVES];
  rgb_t          px_q [HALVES];

  assign wr_ready = 1'b1;
  assign fb_raddr = {rd_line, rd_col};

  led_scan_seq #(
    .COLS(COLS), .LINES(LINES), .HALF_CYC(HALF_CYC), .ON_CYC(ON_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .rd_line(rd_line), .rd_col(rd_col), .ld_px(ld_px),
    .sclk(panel_sclk), .latch(panel_latch), .oe_n(panel_oe_n),
    .addr(panel_addr)
  );

  // top address bit picks the half; the rest is {line, col} inside it
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    led_fb_half #(.DEPTH(DEPTH), .AW(AW)) u_fb (
      .clk(clk),
      .we(wr_valid && (wr_addr[AW] == 1'(h))),
      .waddr(wr_addr[AW-1:0]),
      .wdata(wr_data),
      .raddr(fb_raddr),
      .rdata(fb_q[h])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)     px_q[h] <= '0;
      else if (ld_px) px_q[h] <= fb_q[h];
    end
  end

  assign panel_rgb_top = px_q[0];
  assign panel_rgb_bot = px_q[1];

endmodule

// File: rtl/led_panel_scan_chk.sv
module led_panel_scan_chk #(
  parameter int COLS     = 64,
  parameter int LINES    = 16,
  parameter int HALF_CYC = 1,
  parameter int ON_CYC   = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sclk,
  input logic                     latch,
  input logic                     oe_n,
  input logic [$clog2(LINES)-1:0] addr,
  input logic [2:0]               rgb_top,
  input logic [2:0]               rgb_bot
);

  localparam int LW = $clog2(LINES);

  logic sclk_d, latch_d;
  int   hi_run, lo_run, oe_run, rise_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      latch_d  <= 1'b0;
      hi_run   <= 0;
      lo_run   <= 0;
      oe_run   <= 0;
      rise_cnt <= 0;
    end else begin
      sclk_d  <= sclk;
      latch_d <= latch;
      hi_run  <= sclk ? hi_run + 1 : 0;
      lo_run  <= sclk ? 0 : lo_run + 1;
      oe_run  <= oe_n ? 0 : oe_run + 1;
      if (latch && !latch_d) rise_cnt <= (sclk && !sclk_d) ? 1 : 0;
      else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1;
    end
  end

  AST_COLS_PER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch) |-> rise_cnt == COLS); // R3
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> ($stable(rgb_top) && $stable(rgb_bot))); // R4
  AST_SCLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> hi_run == HALF_CYC); // R5
  AST_SCLK_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> lo_run >= HALF_CYC); // R5
  AST_LATCH_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> (oe_n && !sclk)); // R6
  AST_ADDR_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr) |-> (oe_n && $past(oe_n))); // R7
  AST_ON_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> oe_run == ON_CYC); // R8
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr) |-> (($past(addr) == LW'(LINES - 1)) ? (addr == '0)
                                                         : (addr == $past(addr) + 1'b1))); // R9

endmodule

bind led_panel_scan led_panel_scan_chk #(
  .COLS(COLS), .LINES(LINES), .HALF_CYC(HALF_CYC), .ON_CYC(ON_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(panel_sclk), .latch(panel_latch),
  .oe_n(panel_oe_n), .addr(panel_addr),
  .rgb_top(panel_rgb_top), .rgb_bot(panel_rgb_bot)
);

// File: tb/led_panel_scan_tb_top.sv
module led_panel_scan_tb_top;

  localparam int COLS  = 64;
  localparam int LINES = 16;
  localparam int HALF  = 2;
  localparam int ON    = 24;
  localparam int WAW   = $clog2(LINES) + $clog2(COLS) + 1;
  localparam int NPIX  = 2 * LINES * COLS;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                     rst_n;
  logic                     wr_valid;
  logic                     wr_ready;
  logic [WAW-1:0]           wr_addr;
  logic [2:0]               wr_data;
  logic                     panel_sclk, panel_latch, panel_oe_n;
  logic [$clog2(LINES)-1:0] panel_addr;
  logic [2:0]               panel_rgb_top, panel_rgb_bot;

  led_panel_scan #(.COLS(COLS), .LINES(LINES), .HALF_CYC(HALF), .ON_CYC(ON)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .panel_sclk(panel_sclk), .panel_latch(panel_latch), .panel_oe_n(panel_oe_n),
    .panel_addr(panel_addr), .panel_rgb_top(panel_rgb_top), .panel_rgb_bot(panel_rgb_bot)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // panel model: six shift registers and their latches ([half][R,G,B])
  logic [COLS-1:0] sh  [2][3];
  logic [COLS-1:0] lat [2][3];
  int rises_since = 0, rises_at_latch = 0;
  logic [5:0] rise_data = '0;

  always @(posedge panel_sclk) begin
    for (int k = 0; k < 3; k++) begin
      sh[0][k] <= {sh[0][k][COLS-2:0], panel_rgb_top[2-k]};
      sh[1][k] <= {sh[1][k][COLS-2:0], panel_rgb_bot[2-k]};
    end
    rises_since = rises_since + 1;
    rise_data   = {panel_rgb_top, panel_rgb_bot};
  end

  always @(posedge panel_latch) begin
    for (int h = 0; h < 2; h++)
      for (int k = 0; k < 3; k++) lat[h][k] <= sh[h][k];
    rises_at_latch = rises_since;
    rises_since    = 0;
  end

  // continuous timing watchers, sampled mid-cycle
  int hold_viol = 0, addr_viol = 0, latch_viol = 0, rdy_bad = 0;
  logic [$clog2(LINES)-1:0] prev_addr = '0;
  logic prev_oe = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (panel_sclk && {panel_rgb_top, panel_rgb_bot} != rise_data) hold_viol++;
      if (panel_addr != prev_addr && !(panel_oe_n && prev_oe)) addr_viol++;
      if (panel_latch && (!panel_oe_n || panel_sclk)) latch_viol++;
    end
    prev_addr = panel_addr;
    prev_oe   = panel_oe_n;
  end

  logic [2:0] exp_mem [NPIX];

  function automatic logic [2:0] pat(input int sel, input int r, input int c);
    if (sel == 0) return 3'(r ^ c);
    return 3'(r * 3 + c * 5 + 1);
  endfunction

  task automatic wr(input int row, input int col, input logic [2:0] d, input bit valid);
    @(negedge clk);
    wr_valid = valid;
    wr_addr  = WAW'(row * COLS + col);
    wr_data  = d;
    if (valid) exp_mem[row * COLS + col] = d;
    if (!wr_ready) rdy_bad++;
  endtask

  task automatic fill(input int sel);
    for (int r = 0; r < 2 * LINES; r++)
      for (int c = 0; c < COLS; c++) wr(r, c, pat(sel, r, c), 1'b1);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic check_frame(input string req);
    logic [COLS-1:0] e;
    int cnt;
    do @(negedge panel_oe_n); while (panel_addr != 4'(LINES - 1));
    for (int l = 0; l < LINES; l++) begin
      @(negedge panel_oe_n);
      @(negedge clk);
      chk(panel_addr == 4'(l), "R9 line order", 64'(panel_addr), 64'(l));
      chk(rises_at_latch == COLS, "R3 clocks per line", 64'(rises_at_latch), 64'(COLS));
      for (int h = 0; h < 2; h++)
        for (int k = 0; k < 3; k++) begin
          for (int c = 0; c < COLS; c++)
            e[COLS-1-c] = exp_mem[(l + h * LINES) * COLS + c][2-k];
          chk(lat[h][k] == e, req, lat[h][k], e);
        end
      cnt = 0;
      while (!panel_oe_n) begin
        cnt++;
        @(negedge clk);
      end
      chk(cnt == ON, "R8 on-time", 64'(cnt), 64'(ON));
    end
  endtask

  initial begin
    int hi_n, lo_n;
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk(panel_oe_n == 1'b1, "R1 oe_n in reset", 64'(panel_oe_n), 64'd1);
    chk(panel_sclk == 1'b0, "R1 sclk in reset", 64'(panel_sclk), 64'd0);
    chk(panel_latch == 1'b0, "R1 latch in reset", 64'(panel_latch), 64'd0);
    chk(panel_addr == '0, "R1 addr in reset", 64'(panel_addr), 64'd0);
    chk(wr_ready == 1'b1, "R1 wr_ready", 64'(wr_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(panel_oe_n == 1'b1, "R1 blanked after reset", 64'(panel_oe_n), 64'd1);

    // R5: one shift-clock period at the start of a line
    @(posedge panel_latch);
    @(posedge panel_sclk);
    @(negedge clk);
    hi_n = 0;
    while (panel_sclk) begin hi_n++; @(negedge clk); end
    lo_n = 0;
    while (!panel_sclk) begin lo_n++; @(negedge clk); end
    chk(hi_n == HALF, "R5 sclk high", 64'(hi_n), 64'(HALF));
    chk(lo_n == HALF, "R5 sclk low", 64'(lo_n), 64'(HALF));

    // R2: full fill, then a beat with valid low that must not land
    fill(0);
    wr(2, 5, ~pat(0, 2, 5), 1'b0);
    @(negedge clk);
    wr_valid = 1'b0;
    chk(rdy_bad == 0, "R2 ready during fill", 64'(rdy_bad), 64'd0);
    check_frame("R10 R2 latched row pattern A");

    // R11: rewrite everything while the scan keeps running
    fill(1);
    chk(rdy_bad == 0, "R11 ready during scan", 64'(rdy_bad), 64'd0);
    check_frame("R11 R10 latched row pattern B");

    chk(hold_viol == 0, "R4 data moved while sclk high", 64'(hold_viol), 64'd0);
    chk(addr_viol == 0, "R7 address moved while lit", 64'(addr_viol), 64'd0);
    chk(latch_viol == 0, "R6 latch outside blank", 64'(latch_viol), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule